// File: doc/BRIEF.md
# Receiver Rate Change Sequencer

This block sits between the logic that picks a receiver line rate and the transceiver channel that applies it. It does not pass a new rate straight through. When the requested rate differs from the rate last handed to the channel, the block first clears one configuration bit in the channel. It does this by reading the configuration word over a simple register port and writing it back with only that bit changed. Only then does it forward the new rate to the channel.

The rate change makes the channel's PMA-reset-done status drop. The block waits for that falling edge and restores the configuration bit to its earlier value with a second read-modify-write. The receiver holds its done status low for a long time, well over half a microsecond, and the restore fits inside that window.

A parameter selects a bypass variant for simulation setups with a fast channel reset. In that variant the rate is registered straight through and the register port stays silent.

Top module: `rx_rate_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ch_rate` is 0, `busy` is 0 and `reg_en` is 0. The last forwarded rate counts as 0 after reset.
- R2: A sequence starts when `usr_rate` differs from the last forwarded rate while the block is idle. `busy` is then 1 in the next cycle. While idle, or while waiting for the done status to fall, `reg_en` is never asserted.
- R3: Each sequence begins with a read of address 0x011, followed by a write to 0x011. That write carries the word just read, with bit 11 forced to 0 and all other 15 bits unchanged.
- R4: `ch_rate` takes the new value two clock cycles after the cycle in which `reg_rdy` answers the clearing write, and never before.
- R5: After the rate is forwarded, the block waits for a high-to-low transition of `pma_done`. It then reads 0x011 and writes back the word read, with bit 11 set to the value seen by the clearing read. The write completes while `pma_done` is still low.
- R6: `busy` stays 1 from the start of a sequence until two cycles after `reg_rdy` answers the restoring write, and then returns to 0.
- R7: The value forwarded is `usr_rate` as sampled when the sequence starts. A change made during a sequence starts another sequence once the current one has finished.
- R8: With the bypass parameter set, `ch_rate` equals `usr_rate` delayed by one cycle, `busy` stays 0 and `reg_en` stays 0.
- R9: `reg_en` is a single-cycle pulse and at most one access is outstanding. `reg_we` is only asserted together with `reg_en`. A write is issued only in the cycle after `reg_rdy` answers the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| usr_rate | input | RATE_W | Requested receiver rate |
| pma_done | input | 1 | Channel PMA-reset-done status |
| ch_rate | output | RATE_W | Registered rate driven to the channel |
| busy | output | 1 | High while a rate-change sequence is in progress |
| reg_addr | output | ADDR_W | Register port address (always the configuration address) |
| reg_wdata | output | DATA_W | Register port write data |
| reg_en | output | 1 | Register port access strobe, one cycle per access |
| reg_we | output | 1 | Register port write qualifier |
| reg_rdata | input | DATA_W | Register port read data, valid with `reg_rdy` |
| reg_rdy | input | 1 | Register port completion, one cycle per access |

## Verification
The assertions rely on three things about the inputs. `reg_rdy` pulses once for each access and never arrives before the access is issued. `pma_done` falls only after a new rate has been forwarded. Its low window is long enough for the restore. The bench's register responder answers each access a fixed three cycles after seeing the strobe. Its channel model drops the done status three cycles after a rate update and holds it low for forty cycles. A new drop is deferred until the status has risen again, so a back-to-back sequence still sees a clean falling edge.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_RD_WAIT,
      ENG_WR_WAIT
   } eng_state_t;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_CLEAR,
      SQ_WAIT_FALL,
      SQ_RESTORE
   } seq_state_t;

   typedef enum logic {
      OP_CLEAR,
      OP_RESTORE
   } patch_op_t;

endpackage

// File: rtl/rrs_bit_patcher.sv
// Read-modify-write engine for a single bit of one configuration word.
module rrs_bit_patcher
   import rrs_pkg::*;
#(
   parameter int              ADDR_W    = 9,
   parameter int              DATA_W    = 16,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 9'h011,
   parameter int              PATCH_BIT = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  patch_op_t         op,
   output logic              done,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_en,
   output logic              reg_we,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic              reg_rdy
);

   if (PATCH_BIT >= DATA_W) begin : g_bad_bit
      $error("rrs_bit_patcher: PATCH_BIT outside the data word");
   end
   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("rrs_bit_patcher: widths must be positive");
   end

   eng_state_t        st;
   patch_op_t         cur_op;
   logic              saved_bit;
   logic [DATA_W-1:0] patched;

   always_comb begin
      patched            = reg_rdata;
      patched[PATCH_BIT] = (cur_op == OP_CLEAR) ? 1'b0 : saved_bit;
   end

   assign reg_addr = CFG_ADDR;

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= ENG_IDLE;
         cur_op    <= OP_CLEAR;
         saved_bit <= 1'b0;
         reg_wdata <= '0;
         reg_en    <= 1'b0;
         reg_we    <= 1'b0;
         done      <= 1'b0;
      end else begin
         reg_en <= 1'b0;
         reg_we <= 1'b0;
         done   <= 1'b0;
         unique case (st)
            ENG_IDLE: begin
               if (start) begin
                  cur_op <= op;
                  reg_en <= 1'b1;
                  st     <= ENG_RD_WAIT;
               end
            end
            ENG_RD_WAIT: begin
               if (reg_rdy) begin
                  if (cur_op == OP_CLEAR) begin
                     saved_bit <= reg_rdata[PATCH_BIT];
                  end
                  reg_wdata <= patched;
                  reg_en    <= 1'b1;
                  reg_we    <= 1'b1;
                  st        <= ENG_WR_WAIT;
               end
            end
            ENG_WR_WAIT: begin
               if (reg_rdy) begin
                  done <= 1'b1;
                  st   <= ENG_IDLE;
               end
            end
            default: st <= ENG_IDLE;
         endcase
      end
   end

   // R9
   en_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      reg_en |=> !reg_en);

   // R3
   write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_en && reg_we) |-> $past(reg_rdy));

endmodule

// File: rtl/rrs_seq_ctrl.sv
// Sequence controller: detects a rate change, orders patch, forward, wait and restore.
module rrs_seq_ctrl
   import rrs_pkg::*;
#(
   parameter int RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [RATE_W-1:0] usr_rate,
   input  logic              pma_done,
   input  logic              patch_done,
   output logic              patch_start,
   output patch_op_t         patch_op,
   output logic [RATE_W-1:0] ch_rate,
   output logic              busy
);

   seq_state_t        st;
   logic [RATE_W-1:0] target;
   logic              pd_q;
   logic              pd_fell;

   assign pd_fell = pd_q & ~pma_done;
   assign busy    = (st != SQ_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         st          <= SQ_IDLE;
         target      <= '0;
         ch_rate     <= '0;
         pd_q        <= 1'b0;
         patch_start <= 1'b0;
         patch_op    <= OP_CLEAR;
      end else begin
         pd_q        <= pma_done;
         patch_start <= 1'b0;
         unique case (st)
            SQ_IDLE: begin
               if (usr_rate != ch_rate) begin
                  target      <= usr_rate;
                  patch_op    <= OP_CLEAR;
                  patch_start <= 1'b1;
                  st          <= SQ_CLEAR;
               end
            end
            SQ_CLEAR: begin
               if (patch_done) begin
                  ch_rate <= target;
                  st      <= SQ_WAIT_FALL;
               end
            end
            SQ_WAIT_FALL: begin
               if (pd_fell) begin
                  patch_op    <= OP_RESTORE;
                  patch_start <= 1'b1;
                  st          <= SQ_RESTORE;
               end
            end
            SQ_RESTORE: begin
               if (patch_done) begin
                  st <= SQ_IDLE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   // R4
   rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(ch_rate) |-> $past(patch_done));

endmodule

// File: rtl/rx_rate_seq.sv
module rx_rate_seq
   import rrs_pkg::*;
#(
   parameter int              RATE_W    = 3,
   parameter int              ADDR_W    = 9,
   parameter int              DATA_W    = 16,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 9'h011,
   parameter int              PATCH_BIT = 11,
   parameter bit              BYPASS    = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [RATE_W-1:0] usr_rate,
   input  logic              pma_done,
   output logic [RATE_W-1:0] ch_rate,
   output logic              busy,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_en,
   output logic              reg_we,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic              reg_rdy
);

   if (RATE_W < 1) begin : g_bad_rate
      $error("rx_rate_seq: RATE_W must be at least 1");
   end

   if (BYPASS) begin : g_bypass
      logic [RATE_W-1:0] rate_q;
      logic              unused_bypass;

      always_ff @(posedge clk) begin
         if (rst) rate_q <= '0;
         else     rate_q <= usr_rate;
      end

      assign ch_rate       = rate_q;
      assign busy          = 1'b0;
      assign reg_addr      = CFG_ADDR;
      assign reg_wdata     = '0;
      assign reg_en        = 1'b0;
      assign reg_we        = 1'b0;
      assign unused_bypass = ^{pma_done, reg_rdata, reg_rdy};

      // R8
      bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
         $past(!rst) |-> (ch_rate == $past(usr_rate)));

   end else begin : g_seq
      logic      patch_start;
      logic      patch_done;
      patch_op_t patch_op;

      rrs_seq_ctrl #(
         .RATE_W (RATE_W)
      ) ctrl_i (
         .clk         (clk),
         .rst         (rst),
         .usr_rate    (usr_rate),
         .pma_done    (pma_done),
         .patch_done  (patch_done),
         .patch_start (patch_start),
         .patch_op    (patch_op),
         .ch_rate     (ch_rate),
         .busy        (busy)
      );

      rrs_bit_patcher #(
         .ADDR_W    (ADDR_W),
         .DATA_W    (DATA_W),
         .CFG_ADDR  (CFG_ADDR),
         .PATCH_BIT (PATCH_BIT)
      ) patch_i (
         .clk       (clk),
         .rst       (rst),
         .start     (patch_start),
         .op        (patch_op),
         .done      (patch_done),
         .reg_addr  (reg_addr),
         .reg_wdata (reg_wdata),
         .reg_en    (reg_en),
         .reg_we    (reg_we),
         .reg_rdata (reg_rdata),
         .reg_rdy   (reg_rdy)
      );

      // R2
      quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
         !busy |-> !reg_en);

      // R6
      busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
         $fell(busy) |-> $past(patch_done));
   end

endmodule

// File: tb/rx_rate_seq_tb_top.sv
module rx_rate_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;
   localparam int LOW_LEN    = 40;
   localparam int DROP_DLY   = 3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  usr_rate = 3'd0;
   logic        pma_done = 1'b1;
   logic [15:0] rdata = 16'h0;
   logic        rdy = 1'b0;

   logic [2:0]  ch_rate;
   logic        busy;
   logic [8:0]  reg_addr;
   logic [15:0] reg_wdata;
   logic        reg_en;
   logic        reg_we;

   logic [2:0]  b_ch;
   logic        b_busy;
   logic [8:0]  b_addr;
   logic [15:0] b_wdata;
   logic        b_en;
   logic        b_we;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rx_rate_seq dut_i (
      .clk (clk), .rst (rst), .usr_rate (usr_rate), .pma_done (pma_done),
      .ch_rate (ch_rate), .busy (busy), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_en (reg_en), .reg_we (reg_we),
      .reg_rdata (rdata), .reg_rdy (rdy)
   );

   rx_rate_seq #(.BYPASS (1'b1)) byp_i (
      .clk (clk), .rst (rst), .usr_rate (usr_rate), .pma_done (1'b1),
      .ch_rate (b_ch), .busy (b_busy), .reg_addr (b_addr),
      .reg_wdata (b_wdata), .reg_en (b_en), .reg_we (b_we),
      .reg_rdata (16'h0), .reg_rdy (1'b0)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // reference model state
   int          phase = 0;
   logic [2:0]  m_rate = 3'd0;
   logic [2:0]  m_target = 3'd0;
   bit          m_busy = 1'b0;
   bit          pend = 1'b0;
   bit          m_pd_prev = 1'b0;
   int          seq_cnt = 0;
   // register responder
   bit          outst = 1'b0;
   bit          cur_we = 1'b0;
   bit          ack_we = 1'b0;
   logic [15:0] cur_wd = 16'h0;
   logic [15:0] cfg_word = 16'hA85C;
   int          cnt = 0;
   int          txn = 0;
   bit          orig_b = 1'b0;
   // channel model
   bit          drop_pend = 1'b0;
   bit          win_restored = 1'b0;
   int          drop_cnt = 0;
   int          low_cnt = 0;
   bit          rst_prev = 1'b1;
   logic [2:0]  prev_ch = 3'd0;

   always @(negedge clk) begin
      if (rst) begin
         phase = 0; m_rate = 0; m_busy = 0; pend = 0; m_pd_prev = 0;
         outst = 0; rdy = 0; drop_pend = 0; drop_cnt = 0; low_cnt = 0;
         pma_done = 1; rst_prev = 1; prev_ch = 0;
      end else begin
         automatic bit ackw = rdy && ack_we;
         automatic bit fell = m_pd_prev && !pma_done;
         automatic logic [15:0] exp_wd;
         case (phase)
            0: if (usr_rate != m_rate) begin
                  phase = 1; m_target = usr_rate; m_busy = 1; txn = 0; seq_cnt++;
               end
            1: if (pend) begin pend = 0; m_rate = m_target; phase = 2; end
               else if (ackw) pend = 1;
            2: if (fell) begin phase = 3; txn = 0; end
            default: if (pend) begin pend = 0; phase = 0; m_busy = 0; end
               else if (ackw) pend = 1;
         endcase
         chk(ch_rate == m_rate, "R4 R7 forwarded rate", ch_rate, m_rate);
         chk(busy == m_busy, "R6 busy", busy, m_busy);
         if (ch_rate != prev_ch) begin
            chk(cfg_word[11] == 1'b0, "R4 rate moved while bit 11 set", cfg_word[11], 0);
            drop_pend = 1;
            prev_ch = ch_rate;
         end
         if (!rst_prev) chk(b_ch == usr_rate, "R8 bypass rate", b_ch, usr_rate);
         chk(!b_en && !b_busy, "R8 bypass quiet", {b_en, b_busy}, 0);
         rst_prev = 0;
         m_pd_prev = pma_done;

         // register responder
         if (rdy) rdy = 0;
         if (reg_en) begin
            chk(!outst, "R9 overlapping access", outst, 0);
            chk(reg_addr == 9'h011, "R3 address", reg_addr, 9'h011);
            if (phase == 1 || phase == 3) begin
               if (txn == 0) begin
                  chk(!reg_we, "R3 read first", reg_we, 0);
                  if (phase == 1) orig_b = cfg_word[11];
               end else begin
                  chk(reg_we, "R3 write second", reg_we, 1);
                  exp_wd = cfg_word;
                  exp_wd[11] = (phase == 1) ? 1'b0 : orig_b;
                  if (phase == 1) chk(reg_wdata == exp_wd, "R3 clear data", reg_wdata, exp_wd);
                  else            chk(reg_wdata == exp_wd, "R5 restore data", reg_wdata, exp_wd);
               end
               txn++;
            end else begin
               chk(1'b0, "R2 access outside patch phase", reg_en, 0);
            end
            outst = 1; cur_we = reg_we; cur_wd = reg_wdata; cnt = LAT;
         end else begin
            chk(!reg_we, "R9 write qualifier without strobe", reg_we, 0);
            if (outst) begin
               cnt--;
               if (cnt == 0) begin
                  rdy = 1; ack_we = cur_we; outst = 0;
                  if (cur_we) begin
                     cfg_word = cur_wd;
                     if (phase == 3) win_restored = 1;
                  end else begin
                     rdata = cfg_word;
                  end
               end
            end
         end

         // channel model
         if (drop_pend && pma_done && drop_cnt == 0 && low_cnt == 0) begin
            drop_pend = 0; drop_cnt = DROP_DLY;
         end
         if (drop_cnt > 0) begin
            drop_cnt--;
            if (drop_cnt == 0) begin
               pma_done = 0; low_cnt = LOW_LEN; win_restored = 0;
            end
         end else if (low_cnt > 0) begin
            low_cnt--;
            if (low_cnt == 0) begin
               chk(win_restored, "R5 restore before rise", win_restored, 1);
               pma_done = 1;
            end
         end
      end
   end

   task automatic set_rate(input logic [2:0] v);
      @(negedge clk); #1 usr_rate = v;
   endtask

   task automatic wait_idle();
      int n = 0;
      do begin
         @(negedge clk); #2; n++;
      end while ((busy || phase != 0 || low_cnt > 0 || drop_cnt > 0 || drop_pend) && n < 3000);
      repeat (4) @(negedge clk);
      #2;
   endtask

   initial begin
      int s0;
      repeat (3) @(negedge clk);
      #2;
      chk(ch_rate == 0, "R1 reset rate", ch_rate, 0);
      chk(!busy, "R1 reset busy", busy, 0);
      chk(!reg_en, "R1 reset strobe", reg_en, 0);
      @(negedge clk); #1 rst = 1'b0;
      @(negedge clk); #2;
      chk(ch_rate == 0 && !busy && !reg_en, "R1 after reset", {ch_rate, busy, reg_en}, 0);
      repeat (5) @(negedge clk);

      set_rate(3'd5);
      wait_idle();
      chk(ch_rate == 3'd5, "R7 rate 5", ch_rate, 5);
      chk(cfg_word == 16'hA85C, "R5 word restored (bit set)", cfg_word, 16'hA85C);

      @(negedge clk); #1 cfg_word = 16'h3255;
      set_rate(3'd2);
      wait_idle();
      chk(ch_rate == 3'd2, "R7 rate 2", ch_rate, 2);
      chk(cfg_word == 16'h3255, "R5 word restored (bit clear)", cfg_word, 16'h3255);

      @(negedge clk); #1 cfg_word = 16'hFFFF;
      s0 = seq_cnt;
      set_rate(3'd6);
      repeat (3) @(negedge clk);
      #1 usr_rate = 3'd1;
      wait_idle();
      chk(ch_rate == 3'd1, "R7 queued change", ch_rate, 1);
      chk(seq_cnt == s0 + 2, "R7 two sequences", seq_cnt - s0, 2);
      chk(cfg_word == 16'hFFFF, "R5 word restored twice", cfg_word, 16'hFFFF);

      s0 = seq_cnt;
      set_rate(3'd1);
      repeat (12) @(negedge clk);
      #2;
      chk(seq_cnt == s0 && !busy, "R2 same value ignored", seq_cnt - s0, 0);

      @(negedge clk); #1 cfg_word = 16'h0000;
      set_rate(3'd7);
      wait_idle();
      chk(ch_rate == 3'd7, "R7 rate 7", ch_rate, 7);
      set_rate(3'd0);
      wait_idle();
      chk(ch_rate == 3'd0, "R7 rate 0", ch_rate, 0);
      chk(cfg_word == 16'h0000, "R5 zero word kept", cfg_word, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "R6 watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule